// File: doc/BRIEF.md
# Control-Byte Register Access Port

This block sits between a host's cyclic process image and a serial channel. Every cycle the host presents one control byte and two data bytes. The block answers with one status byte and two data bytes. When the mode bit of the control byte is clear, the data bytes pass straight through. The host's two bytes go to the serial transmit side, and the word received from the serial side goes back to the host.

When the mode bit is set, the two data bytes are taken away from process traffic. They are used instead to read or write one 16-bit word in a 64-entry configuration file. The configuration file holds a feature word, a baud divisor and two timeout words, and these drive the block's configuration outputs. The host requests a write, then waits until the status byte echoes its request. After the echo it may move on.

Top module: `cbyte_regport`

## Requirements
- R1: While reset is held, and after it is released, the status byte, the device data bytes and `pd_tx` are zero. The configuration outputs are reset as follows: `cfg_feature` is 0x0007, `cfg_baud_div` is 0x03, and `cfg_rx_timeout` and `cfg_tx_timeout` are 0x0014. Register 16 reads 0x0102, and register 63 reads zero.
- R2: Process mode is selected when control bit 7 is 0. Bits 6..0 of the control byte are then ignored. After the next clock edge:
  - `pd_tx` equals {`host_hi`, `host_lo`};
  - {`dev_hi`, `dev_lo`} equals the `pd_rx` value sampled at that edge;
  - the status byte is 0x00.
- R3: A read is a control byte with bit 7 = 1 and bit 6 = 0. It selects register address = control bits 5..0. After the next edge, {`dev_hi`, `dev_lo`} holds that register's word. The register is not changed. `pd_tx` keeps its value, and `pd_rx` has no effect on the outputs.
- R4: In register mode, the status byte after the next edge is {1, 0, address}. For example, control 0xE1 gives status 0xA1.
- R5: A write is a control byte with bit 6 = 1 (and bit 7 = 1). It stores {`host_hi`, `host_lo`} into a writable register at that edge. In the same cycle the data bytes return the register's previous word. Registers 32 (feature), 33 (baud), 34 (receive timeout) and 35 (transmit timeout) drive `cfg_feature`, `cfg_baud_div`, `cfg_rx_timeout` and `cfg_tx_timeout`.
- R6: A write is performed only in a cycle whose control byte differs from the control byte of the cycle before. Holding the same write control byte does not store new data, even if the data changes. Any different control byte in between re-arms the write.
- R7: Addresses 0 to 31 are read-only and ignore writes, with one exception: register 16 is writable. The read-only registers other than 16 read as zero.
- R8: `cfg_baud_div` is the low byte of register 33. The high byte has no effect on it, but it is stored and read back.
- R9: All 64 addresses decode separately. A write to address 63 does not disturb register 32, and a write to one configuration register leaves the other configuration outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_byte | input | 8 | Host control byte: bit 7 mode, bit 6 write, bits 5..0 address |
| host_lo | input | 8 | Host data byte, low half of word |
| host_hi | input | 8 | Host data byte, high half of word |
| pd_rx | input | 16 | Word received from the serial side |
| status_byte | output | 8 | Status byte returned to the host |
| dev_lo | output | 8 | Returned data byte, low half |
| dev_hi | output | 8 | Returned data byte, high half |
| pd_tx | output | 16 | Word handed to the serial transmit side |
| cfg_feature | output | 16 | Feature word (register 32) |
| cfg_baud_div | output | 8 | Baud divisor, low byte of register 33 |
| cfg_rx_timeout | output | 16 | Receive timeout word (register 34) |
| cfg_tx_timeout | output | 16 | Transmit timeout word (register 35) |

## Verification
A corrupted register word shows on the configuration outputs in the same cycle as the corrupting edge. It also shows on the data bytes one edge after the host reads that address. A stuck or stale write-edge detector shows up in two ways: a repeated write changes a configuration output, or a re-armed write fails to change it, one edge after the request. A wrong address decode or a wrong mode decode shows in the status echo or the pass-through word at the very next edge.

// File: rtl/cbyte_pkg.sv
package cbyte_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned WORD_W = 2 * BYTE_W;
   localparam int unsigned ADDR_W = BYTE_W - 2;
   localparam int unsigned NREG   = 1 << ADDR_W;

   typedef logic [BYTE_W-1:0] byte_t;
   typedef logic [WORD_W-1:0] word_t;
   typedef logic [ADDR_W-1:0] addr_t;

   // control byte layout: mode, direction, address
   typedef struct packed {
      logic  reg_mode;
      logic  write;
      addr_t addr;
   } ctrl_t;

   localparam byte_t STAT_IDLE = '0;

   function automatic byte_t status_echo(input addr_t a);
      return {1'b1, 1'b0, a};
   endfunction
endpackage

// File: rtl/cbyte_ctrl_decode.sv
module cbyte_ctrl_decode
   import cbyte_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  byte_t ctrl_byte,
   output logic  reg_mode,
   output logic  wr_pulse,
   output addr_t addr
);
   ctrl_t cur;
   byte_t prev_q;

   assign cur = ctrl_t'(ctrl_byte);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= ctrl_byte;
   end

   assign reg_mode = cur.reg_mode;
   assign addr     = cur.addr;
   // a write fires only when the control byte is new this cycle
   assign wr_pulse = cur.reg_mode & cur.write & (ctrl_byte != prev_q);
endmodule

// File: rtl/cbyte_reg_file.sv
module cbyte_reg_file
   import cbyte_pkg::*;
#(
   parameter int unsigned USER_BASE  = 32,
   parameter int unsigned MFG_ADDR   = 16,
   parameter int unsigned FEAT_ADDR  = 32,
   parameter int unsigned BAUD_ADDR  = 33,
   parameter int unsigned RTMO_ADDR  = 34,
   parameter int unsigned TTMO_ADDR  = 35,
   parameter word_t       HW_VERSION = 16'h0102,
   parameter word_t       FEAT_RST   = 16'h0007,
   parameter word_t       BAUD_RST   = 16'h0003,
   parameter word_t       RTMO_RST   = 16'h0014,
   parameter word_t       TTMO_RST   = 16'h0014
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  we,
   input  addr_t addr,
   input  word_t wd,
   output word_t rd,
   output word_t feature,
   output byte_t baud_lo,
   output word_t rx_tmo,
   output word_t tx_tmo
);
   word_t regs [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      localparam word_t RST =
         (i == FEAT_ADDR) ? FEAT_RST :
         (i == BAUD_ADDR) ? BAUD_RST :
         (i == RTMO_ADDR) ? RTMO_RST :
         (i == TTMO_ADDR) ? TTMO_RST :
         (i == MFG_ADDR)  ? HW_VERSION : word_t'(0);

      if (i >= USER_BASE || i == MFG_ADDR) begin : g_rw
         word_t q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         q <= RST;
            else if (we && addr == addr_t'(i))  q <= wd;
         end
         assign regs[i] = q;
      end else begin : g_ro
         assign regs[i] = RST;
      end
   end

   assign rd      = regs[addr];
   assign feature = regs[FEAT_ADDR];
   assign baud_lo = regs[BAUD_ADDR][BYTE_W-1:0];
   assign rx_tmo  = regs[RTMO_ADDR];
   assign tx_tmo  = regs[TTMO_ADDR];
endmodule

// File: rtl/cbyte_out_stage.sv
module cbyte_out_stage
   import cbyte_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  reg_mode,
   input  addr_t addr,
   input  word_t rd_word,
   input  word_t pd_rx,
   input  word_t host_word,
   output byte_t status,
   output word_t dev_word,
   output word_t pd_tx
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status   <= STAT_IDLE;
         dev_word <= '0;
         pd_tx    <= '0;
      end else if (reg_mode) begin
         status   <= status_echo(addr);
         dev_word <= rd_word;
      end else begin
         status   <= STAT_IDLE;
         dev_word <= pd_rx;
         pd_tx    <= host_word;
      end
   end
endmodule

// File: rtl/cbyte_regport.sv
module cbyte_regport
   import cbyte_pkg::*;
#(
   parameter int unsigned USER_BASE  = 32,
   parameter int unsigned MFG_ADDR   = 16,
   parameter int unsigned FEAT_ADDR  = 32,
   parameter int unsigned BAUD_ADDR  = 33,
   parameter int unsigned RTMO_ADDR  = 34,
   parameter int unsigned TTMO_ADDR  = 35,
   parameter logic [15:0] HW_VERSION = 16'h0102,
   parameter logic [15:0] FEAT_RST   = 16'h0007,
   parameter logic [15:0] BAUD_RST   = 16'h0003,
   parameter logic [15:0] RTMO_RST   = 16'h0014,
   parameter logic [15:0] TTMO_RST   = 16'h0014
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [7:0]  ctrl_byte,
   input  logic [7:0]  host_lo,
   input  logic [7:0]  host_hi,
   input  logic [15:0] pd_rx,
   output logic [7:0]  status_byte,
   output logic [7:0]  dev_lo,
   output logic [7:0]  dev_hi,
   output logic [15:0] pd_tx,
   output logic [15:0] cfg_feature,
   output logic [7:0]  cfg_baud_div,
   output logic [15:0] cfg_rx_timeout,
   output logic [15:0] cfg_tx_timeout
);
   // elaboration-time parameter checks
   if (MFG_ADDR >= USER_BASE) begin : g_bad_mfg
      $error("manufacturer register must lie below the user area");
   end
   if (USER_BASE > NREG) begin : g_bad_base
      $error("user area base beyond register file");
   end
   if (FEAT_ADDR < USER_BASE || BAUD_ADDR < USER_BASE ||
       RTMO_ADDR < USER_BASE || TTMO_ADDR < USER_BASE ||
       FEAT_ADDR >= NREG || BAUD_ADDR >= NREG ||
       RTMO_ADDR >= NREG || TTMO_ADDR >= NREG) begin : g_bad_cfg
      $error("configuration registers must be writable and in range");
   end
   if (FEAT_ADDR == BAUD_ADDR || FEAT_ADDR == RTMO_ADDR || FEAT_ADDR == TTMO_ADDR ||
       BAUD_ADDR == RTMO_ADDR || BAUD_ADDR == TTMO_ADDR ||
       RTMO_ADDR == TTMO_ADDR) begin : g_bad_dup
      $error("configuration register addresses must be distinct");
   end

   logic  reg_mode, wr_pulse;
   addr_t addr;
   word_t rd_word, dev_word, host_word;

   assign host_word = {host_hi, host_lo};

   cbyte_ctrl_decode u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_byte (ctrl_byte),
      .reg_mode  (reg_mode),
      .wr_pulse  (wr_pulse),
      .addr      (addr)
   );

   cbyte_reg_file #(
      .USER_BASE (USER_BASE), .MFG_ADDR (MFG_ADDR),
      .FEAT_ADDR (FEAT_ADDR), .BAUD_ADDR (BAUD_ADDR),
      .RTMO_ADDR (RTMO_ADDR), .TTMO_ADDR (TTMO_ADDR),
      .HW_VERSION(HW_VERSION), .FEAT_RST (FEAT_RST),
      .BAUD_RST  (BAUD_RST),  .RTMO_RST (RTMO_RST),
      .TTMO_RST  (TTMO_RST)
   ) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (wr_pulse),
      .addr    (addr),
      .wd      (host_word),
      .rd      (rd_word),
      .feature (cfg_feature),
      .baud_lo (cfg_baud_div),
      .rx_tmo  (cfg_rx_timeout),
      .tx_tmo  (cfg_tx_timeout)
   );

   cbyte_out_stage u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_mode  (reg_mode),
      .addr      (addr),
      .rd_word   (rd_word),
      .pd_rx     (pd_rx),
      .host_word (host_word),
      .status    (status_byte),
      .dev_word  (dev_word),
      .pd_tx     (pd_tx)
   );

   assign dev_lo = dev_word[7:0];
   assign dev_hi = dev_word[15:8];
endmodule

// File: rtl/cbyte_regport_chk.sv
module cbyte_regport_chk #(
   parameter int unsigned FEAT_ADDR = 32,
   parameter int unsigned BAUD_ADDR = 33
) (
   input logic        clk,
   input logic        rst_n,
   input logic [7:0]  ctrl_byte,
   input logic [15:0] pd_rx,
   input logic [7:0]  status_byte,
   input logic [7:0]  dev_lo,
   input logic [7:0]  dev_hi,
   input logic [15:0] pd_tx,
   input logic [15:0] cfg_feature,
   input logic [7:0]  cfg_baud_div
);
   // R2: process mode passes the serial word back and reports idle status
   assert_proc_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_byte[7] |=> (status_byte == 8'h00) && ({dev_hi, dev_lo} == $past(pd_rx)));

   // R3: register mode leaves the transmit word alone
   assert_pdtx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_byte[7] |=> $stable(pd_tx));

   // R4: register mode echoes the address with the mode flag
   assert_status_echo_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_byte[7] |=> status_byte == {2'b10, $past(ctrl_byte[5:0])});

   // R6: a held write to the feature register does not store again
   assert_write_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && ctrl_byte == $past(ctrl_byte) && ctrl_byte[7:6] == 2'b11 &&
       ctrl_byte[5:0] == 6'(FEAT_ADDR)) |=> $stable(cfg_feature));

   // R8: the divisor moves only on a write to the baud register
   assert_baud_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctrl_byte[7:6] == 2'b11 && ctrl_byte[5:0] == 6'(BAUD_ADDR)) |=> $stable(cfg_baud_div));
endmodule

bind cbyte_regport cbyte_regport_chk #(
   .FEAT_ADDR (FEAT_ADDR),
   .BAUD_ADDR (BAUD_ADDR)
) u_chk (.*);

// File: tb/cbyte_regport_tb.sv
module cbyte_regport_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 13;

   // {ctrl, host_hi, host_lo, pd_rx, exp_status, exp_dev, exp_pd_tx}
   localparam logic [79:0] VEC [NVEC] = '{
      {8'h00, 8'h12, 8'h34, 16'hBEEF, 8'h00, 16'hBEEF, 16'h1234}, // R2 pass-through
      {8'hA0, 8'h00, 8'h00, 16'hFFFF, 8'hA0, 16'h0007, 16'h1234}, // R3 R4 read feature
      {8'hE1, 8'h5A, 8'h09, 16'hFFFF, 8'hA1, 16'h0003, 16'h1234}, // R5 write baud, old word back
      {8'hE1, 8'h77, 8'h77, 16'hFFFF, 8'hA1, 16'h5A09, 16'h1234}, // R6 held write, new word visible
      {8'hA1, 8'h00, 8'h00, 16'hFFFF, 8'hA1, 16'h5A09, 16'h1234}, // R6 not rewritten
      {8'hC5, 8'h11, 8'h11, 16'hFFFF, 8'h85, 16'h0000, 16'h1234}, // R7 write read-only
      {8'h85, 8'h00, 8'h00, 16'hFFFF, 8'h85, 16'h0000, 16'h1234}, // R7 still zero
      {8'hD0, 8'h02, 8'h03, 16'hFFFF, 8'h90, 16'h0102, 16'h1234}, // R7 manufacturer reg writable
      {8'h90, 8'h00, 8'h00, 16'hFFFF, 8'h90, 16'h0203, 16'h1234}, // R7 read back
      {8'hFF, 8'hCA, 8'hFE, 16'hFFFF, 8'hBF, 16'h0000, 16'h1234}, // R9 write top address
      {8'hA0, 8'h00, 8'h00, 16'hFFFF, 8'hA0, 16'h0007, 16'h1234}, // R9 no alias to 32
      {8'hBF, 8'h00, 8'h00, 16'hFFFF, 8'hBF, 16'hCAFE, 16'h1234}, // R9 top address holds
      {8'h22, 8'h44, 8'h55, 16'h0A0B, 8'h00, 16'h0A0B, 16'h4455}  // R2 low bits ignored
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  ctrl_byte = '0, host_lo = '0, host_hi = '0;
   logic [15:0] pd_rx = '0;
   logic [7:0]  status_byte, dev_lo, dev_hi, cfg_baud_div;
   logic [15:0] pd_tx, cfg_feature, cfg_rx_timeout, cfg_tx_timeout;

   int errors = 0, checks = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cbyte_regport u_dut (.*);

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [7:0] c, input logic [15:0] w, input logic [15:0] rx);
      @(negedge clk);
      ctrl_byte = c; host_hi = w[15:8]; host_lo = w[7:0]; pd_rx = rx;
      @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 status in reset", 32'(status_byte), 32'h00);
      check("R1 dev in reset", 32'({dev_hi, dev_lo}), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 pd_tx after reset", 32'(pd_tx), 32'h0);
      check("R1 feature reset", 32'(cfg_feature), 32'h0007);
      check("R1 baud reset", 32'(cfg_baud_div), 32'h03);
      check("R1 rx timeout reset", 32'(cfg_rx_timeout), 32'h0014);
      check("R1 tx timeout reset", 32'(cfg_tx_timeout), 32'h0014);

      for (int i = 0; i < NVEC; i++) begin
         drive(VEC[i][79:72], VEC[i][71:56], VEC[i][55:40]);
         check($sformatf("R2-R9 vec %0d status", i), 32'(status_byte), 32'(VEC[i][39:32]));
         check($sformatf("R2-R9 vec %0d dev", i), 32'({dev_hi, dev_lo}), 32'(VEC[i][31:16]));
         check($sformatf("R2-R9 vec %0d pd_tx", i), 32'(pd_tx), 32'(VEC[i][15:0]));
      end
      check("R8 divisor from low byte", 32'(cfg_baud_div), 32'h09);
      check("R9 feature untouched", 32'(cfg_feature), 32'h0007);

      // R6 re-armed write after a different control byte
      drive(8'hE1, 16'h0011, 16'h0);
      check("R6 rearmed write", 32'(cfg_baud_div), 32'h11);
      drive(8'hE1, 16'h0022, 16'h0);
      check("R6 held write ignored", 32'(cfg_baud_div), 32'h11);
      drive(8'hA1, 16'h0, 16'h0);
      check("R6 stored word", 32'({dev_hi, dev_lo}), 32'h0011);
      // R8 high byte of divisor register
      drive(8'hE1, 16'hEE44, 16'h0);
      check("R8 high byte no effect", 32'(cfg_baud_div), 32'h44);
      check("R4 write echo", 32'(status_byte), 32'hA1);
      drive(8'hA1, 16'h0, 16'h0);
      check("R8 full word stored", 32'({dev_hi, dev_lo}), 32'hEE44);
      // R5 timeout registers
      drive(8'hE2, 16'h0032, 16'h0);
      check("R5 rx timeout write", 32'(cfg_rx_timeout), 32'h0032);
      check("R9 tx timeout kept", 32'(cfg_tx_timeout), 32'h0014);
      drive(8'hE3, 16'h0001, 16'h0);
      check("R5 tx timeout write", 32'(cfg_tx_timeout), 32'h0001);
      check("R9 rx timeout kept", 32'(cfg_rx_timeout), 32'h0032);
      drive(8'h9F, 16'h0, 16'h0);
      check("R7 read-only 31 zero", 32'({dev_hi, dev_lo}), 32'h0);

      // R1 reset in mid-run
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1 mid reset feature", 32'(cfg_feature), 32'h0007);
      check("R1 mid reset baud", 32'(cfg_baud_div), 32'h03);
      check("R1 mid reset rx timeout", 32'(cfg_rx_timeout), 32'h0014);
      check("R1 mid reset tx timeout", 32'(cfg_tx_timeout), 32'h0014);
      check("R1 mid reset status", 32'(status_byte), 32'h00);
      check("R1 mid reset pd_tx", 32'(pd_tx), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      drive(8'hBF, 16'h0, 16'h0);
      check("R1 top register cleared", 32'({dev_hi, dev_lo}), 32'h0);
      drive(8'h90, 16'h0, 16'h0);
      check("R1 manufacturer reset", 32'({dev_hi, dev_lo}), 32'h0102);
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         finish_run();
      end
   end
endmodule